// File: doc/BRIEF.md
# Time and Calendar Update Engine

This block holds the time-of-day and calendar counters of a real-time clock: seconds, minutes, hours, day of the week, day of the month, month, year and a century byte. Each one-second update pulse moves the stored time forward by one second. Every carry is resolved in that same clock cycle, including month lengths, leap years, a daylight-saving jump forward in spring and a fall-back in autumn.

The bytes can be kept in binary or in BCD, and the hours can follow a 24-hour or a 12-hour convention with a PM flag. Both choices are read at every update, so software can change them at run time. A freeze input decouples what software sees from the running count. While the freeze is high, reads return a stable snapshot and writes land in that snapshot. The internal count keeps advancing. When the freeze drops, only the bytes that were written are copied into the running count.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the bytes read sec 0x00, min 0x00, hour 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00 and century 0x20, and `done_o` is low.
- R2: Byte addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year and 7 century. `rd_data_o` shows the addressed byte combinationally.
- R3: Each cycle with `tick_i` high advances the time by one second, carrying into minutes, hours, date, month and year. The counting is binary when `fmt_bin_i`=1 and BCD (tens in bits 7:4, units in bits 3:0) when `fmt_bin_i`=0.
- R4: With `fmt_24h_i`=0 the hour byte holds 1..12 in bits 6:0, and bit 7 set means PM. 11:59:59 AM goes to 12:00:00 PM, 12:59:59 goes to 1:00:00, and 11:59:59 PM goes to 12:00:00 AM of the next day. With `fmt_24h_i`=1 hours run 0..23.
- R5: The weekday counts 1..7, with 1 meaning Sunday. It advances only when the time passes midnight, and 7 wraps to 1.
- R6: The date wraps after 30 days in April, June, September and November, after 31 days in the other months, and after 28 days in February. February has 29 days when the year is a multiple of four.
- R7: When the year wraps from 99 to 00, bits 6:0 of the century byte are loaded with BCD 20 and bit 7 keeps its value.
- R8: With `dst_en_i`=1, a Sunday in April with date 1..7 goes from 01:59:59 to 03:00:00.
- R9: With `dst_en_i`=1, a Sunday in October with date 25 or later goes from 01:59:59 back to 01:00:00 the first time only. The second pass reaches 02:00:00. The flag that blocks a second fall-back clears at midnight.
- R10: While `freeze_i`=1, reads return the bytes as they were when the freeze started, plus any writes made during the freeze. The internal count keeps advancing on each tick.
- R11: When `freeze_i` falls, the bytes written during the freeze replace the internal ones. Bytes that were not written keep the advanced internal values.
- R12: Bit 7 of the seconds byte is ignored on write and always reads 0.
- R13: `done_o` is high for exactly the one cycle that follows each cycle with `tick_i` high.
- R14: A write with `freeze_i`=0 goes to the running count and can be read back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second update pulse, one cycle wide |
| fmt_bin_i | input | 1 | 1 selects binary bytes, 0 selects BCD bytes |
| fmt_24h_i | input | 1 | 1 selects 24-hour hours, 0 selects 12-hour hours with PM flag |
| dst_en_i | input | 1 | Enables the daylight-saving jumps |
| freeze_i | input | 1 | Freezes the software view and redirects writes into it |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 3 | Byte address for reads and writes |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i` |
| done_o | output | 1 | One-cycle strobe after each completed advance |

## Verification
The bench goes after the carry chain at its edges. The cases are end of month in long, short and February months, with and without a leap year, the year 99 wrap with a set century bit 7, and the three 12-hour boundaries in both number formats. A design that got these wrong would show dates such as 31 April or 29 February 2023, lose the century flag, or show hour 00 or 13 in 12-hour mode. Both daylight-saving jumps are exercised, along with negative cases outside the first April week. The autumn hour is run through twice, so an engine that repeats it forever, or never repeats it, is caught. The freeze tests tick while frozen and then release with one byte written. A design that froze the internal count, or copied back every byte, would show the old seconds after release.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int FIELD_W  = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC  = 3'd0,
        A_MIN  = 3'd1,
        A_HOUR = 3'd2,
        A_DOW  = 3'd3,
        A_DATE = 3'd4,
        A_MON  = 3'd5,
        A_YEAR = 3'd6,
        A_CENT = 3'd7
    } reg_addr_e;

    typedef logic [NUM_REGS-1:0][BYTE_W-1:0] reg_file_t;

    // Decoded time, always plain binary, hours on a 0..23 scale
    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] dow;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] mon;
        logic [FIELD_W-1:0] year;
    } cal_t;

    localparam logic [BYTE_W-1:0] SEC_MASK  = 8'h7F;
    localparam logic [BYTE_W-1:0] CENT_LOAD = 8'h20;

    // index 7 down to 0: century, year, month, date, weekday, hour, min, sec
    localparam reg_file_t RESET_REGS = {8'h20, 8'h00, 8'h01, 8'h01,
                                        8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [FIELD_W-1:0] from_field(input logic [BYTE_W-1:0] raw,
                                                      input logic bin);
        logic [BYTE_W-1:0] bcd_val;
        bcd_val = {4'b0, raw[7:4]} * 8'd10 + {4'b0, raw[3:0]};
        return bin ? raw[FIELD_W-1:0] : FIELD_W'(bcd_val);
    endfunction

    function automatic logic [BYTE_W-1:0] to_field(input logic [FIELD_W-1:0] v,
                                                   input logic bin);
        logic [BYTE_W-1:0] wide;
        wide = {1'b0, v};
        return bin ? wide : (((wide / 8'd10) << 4) | (wide % 8'd10));
    endfunction

    function automatic logic [FIELD_W-1:0] month_days(input logic [FIELD_W-1:0] mon,
                                                      input logic [FIELD_W-1:0] year);
        case (mon)
            7'd2:                     return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
            default:                  return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
    import rtc_cal_pkg::*;
(
    input  reg_file_t         regs_i,
    input  logic              bin_i,
    input  logic              h24_i,
    output cal_t              cal_o,
    output logic [BYTE_W-1:0] cent_o
);

    logic [FIELD_W-1:0] hour_raw;
    logic [FIELD_W-1:0] hour_base;
    logic               pm;

    always_comb begin
        cal_o.sec  = from_field(regs_i[A_SEC] & SEC_MASK, bin_i);
        cal_o.min  = from_field(regs_i[A_MIN], bin_i);
        cal_o.dow  = from_field(regs_i[A_DOW], bin_i);
        cal_o.date = from_field(regs_i[A_DATE], bin_i);
        cal_o.mon  = from_field(regs_i[A_MON], bin_i);
        cal_o.year = from_field(regs_i[A_YEAR], bin_i);

        pm        = regs_i[A_HOUR][7];
        hour_raw  = from_field({1'b0, regs_i[A_HOUR][6:0]}, bin_i);
        hour_base = (hour_raw == 7'd12) ? 7'd0 : hour_raw;
        if (h24_i)
            cal_o.hour = hour_raw;
        else
            cal_o.hour = hour_base + (pm ? 7'd12 : 7'd0);
    end

    assign cent_o = regs_i[A_CENT];

endmodule

// File: rtl/rtc_encode.sv
module rtc_encode
    import rtc_cal_pkg::*;
(
    input  cal_t              cal_i,
    input  logic [BYTE_W-1:0] cent_i,
    input  logic              bin_i,
    input  logic              h24_i,
    output reg_file_t         regs_o
);

    logic [FIELD_W-1:0] h12;
    logic               pm;

    always_comb begin
        pm = (cal_i.hour >= 7'd12);
        if (cal_i.hour == 7'd0)
            h12 = 7'd12;
        else if (cal_i.hour > 7'd12)
            h12 = cal_i.hour - 7'd12;
        else
            h12 = cal_i.hour;

        regs_o         = '0;
        regs_o[A_SEC]  = to_field(cal_i.sec, bin_i) & SEC_MASK;
        regs_o[A_MIN]  = to_field(cal_i.min, bin_i);
        regs_o[A_DOW]  = to_field(cal_i.dow, bin_i);
        regs_o[A_DATE] = to_field(cal_i.date, bin_i);
        regs_o[A_MON]  = to_field(cal_i.mon, bin_i);
        regs_o[A_YEAR] = to_field(cal_i.year, bin_i);
        regs_o[A_CENT] = cent_i;
        if (h24_i)
            regs_o[A_HOUR] = to_field(cal_i.hour, bin_i);
        else
            regs_o[A_HOUR] = to_field(h12, bin_i) | {pm, 7'b0};
    end

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_cal_pkg::*;
(
    input  cal_t cur_i,
    input  logic dst_en_i,
    input  logic fb_done_i,
    output cal_t nxt_o,
    output logic midnight_o,
    output logic fallback_o,
    output logic year_wrap_o
);

    logic               at_159;
    logic               spring;
    logic               autumn;
    logic [FIELD_W-1:0] days;

    always_comb begin
        days   = month_days(cur_i.mon, cur_i.year);
        at_159 = (cur_i.hour == 7'd1) && (cur_i.min == 7'd59) && (cur_i.sec == 7'd59);
        spring = dst_en_i && at_159 && (cur_i.dow == 7'd1)
               && (cur_i.mon == 7'd4) && (cur_i.date <= 7'd7);
        autumn = dst_en_i && at_159 && (cur_i.dow == 7'd1)
               && (cur_i.mon == 7'd10) && (cur_i.date >= 7'd25) && !fb_done_i;

        nxt_o       = cur_i;
        midnight_o  = 1'b0;
        fallback_o  = 1'b0;
        year_wrap_o = 1'b0;

        if (spring) begin
            nxt_o.hour = 7'd3;
            nxt_o.min  = 7'd0;
            nxt_o.sec  = 7'd0;
        end else if (autumn) begin
            nxt_o.min  = 7'd0;
            nxt_o.sec  = 7'd0;
            fallback_o = 1'b1;
        end else if (cur_i.sec < 7'd59) begin
            nxt_o.sec = cur_i.sec + 7'd1;
        end else begin
            nxt_o.sec = 7'd0;
            if (cur_i.min < 7'd59) begin
                nxt_o.min = cur_i.min + 7'd1;
            end else begin
                nxt_o.min = 7'd0;
                if (cur_i.hour < 7'd23) begin
                    nxt_o.hour = cur_i.hour + 7'd1;
                end else begin
                    nxt_o.hour = 7'd0;
                    midnight_o = 1'b1;
                    nxt_o.dow  = (cur_i.dow >= 7'd7) ? 7'd1 : cur_i.dow + 7'd1;
                    if (cur_i.date < days) begin
                        nxt_o.date = cur_i.date + 7'd1;
                    end else begin
                        nxt_o.date = 7'd1;
                        if (cur_i.mon < 7'd12) begin
                            nxt_o.mon = cur_i.mon + 7'd1;
                        end else begin
                            nxt_o.mon = 7'd1;
                            if (cur_i.year < 7'd99) begin
                                nxt_o.year = cur_i.year + 7'd1;
                            end else begin
                                nxt_o.year  = 7'd0;
                                year_wrap_o = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_cal_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                freeze_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BYTE_W-1:0]   wr_byte_i,
    input  reg_file_t           live_i,
    output reg_file_t           usr_o,
    output logic [NUM_REGS-1:0] dirty_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            usr_o   <= RESET_REGS;
            dirty_o <= '0;
        end else if (!freeze_i) begin
            usr_o   <= live_i;
            dirty_o <= '0;
        end else if (wr_en_i) begin
            usr_o[addr_i]   <= wr_byte_i;
            dirty_o[addr_i] <= 1'b1;
        end
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              fmt_bin_i,
    input  logic              fmt_24h_i,
    input  logic              dst_en_i,
    input  logic              freeze_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              done_o
);

    reg_file_t           cur_q;
    reg_file_t           cur_d;
    reg_file_t           base;
    reg_file_t           adv_regs;
    reg_file_t           usr_q;
    logic [NUM_REGS-1:0] dirty_q;
    logic                freeze_q;
    logic                fb_done_q;
    logic                release_w;
    logic [BYTE_W-1:0]   wr_byte;
    logic [BYTE_W-1:0]   cent_base;
    logic [BYTE_W-1:0]   cent_next;
    cal_t                base_cal;
    cal_t                next_cal;
    logic                midnight_w;
    logic                fallback_w;
    logic                year_wrap_w;

    assign release_w = freeze_q && !freeze_i;
    assign wr_byte   = (addr_i == A_SEC) ? (wr_data_i & SEC_MASK) : wr_data_i;

    // On release, the bytes written during the freeze replace the running ones
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_merge
            assign base[g] = (release_w && dirty_q[g]) ? usr_q[g] : cur_q[g];
        end
    endgenerate

    rtc_decode u_dec (
        .regs_i (base),
        .bin_i  (fmt_bin_i),
        .h24_i  (fmt_24h_i),
        .cal_o  (base_cal),
        .cent_o (cent_base)
    );

    rtc_advance u_adv (
        .cur_i       (base_cal),
        .dst_en_i    (dst_en_i),
        .fb_done_i   (fb_done_q),
        .nxt_o       (next_cal),
        .midnight_o  (midnight_w),
        .fallback_o  (fallback_w),
        .year_wrap_o (year_wrap_w)
    );

    assign cent_next = year_wrap_w ? {cent_base[7], CENT_LOAD[6:0]} : cent_base;

    rtc_encode u_enc (
        .cal_i  (next_cal),
        .cent_i (cent_next),
        .bin_i  (fmt_bin_i),
        .h24_i  (fmt_24h_i),
        .regs_o (adv_regs)
    );

    always_comb begin
        cur_d = tick_i ? adv_regs : base;
        if (wr_en_i && !freeze_i)
            cur_d[addr_i] = wr_byte;
    end

    rtc_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .freeze_i  (freeze_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_byte_i (wr_byte),
        .live_i    (cur_d),
        .usr_o     (usr_q),
        .dirty_o   (dirty_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= RESET_REGS;
            freeze_q  <= 1'b0;
            fb_done_q <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            cur_q    <= cur_d;
            freeze_q <= freeze_i;
            done_o   <= tick_i;
            if (tick_i && midnight_w)
                fb_done_q <= 1'b0;
            else if (tick_i && fallback_w)
                fb_done_q <= 1'b1;
        end
    end

    assign rd_data_o = freeze_i ? usr_q[addr_i] : cur_q[addr_i];

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              done_o,
    input logic              freeze_i,
    input logic              freeze_q,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BYTE_W-1:0] rd_data_o,
    input reg_file_t         usr_q,
    input reg_file_t         cur_q
);

    AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> done_o);  // R13

    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !done_o);  // R13

    AST_SEC_MSB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr_i == A_SEC) |-> !rd_data_o[7]);  // R12

    AST_FROZEN_VIEW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && !wr_en_i) |=> $stable(usr_q));  // R10

    AST_CENT_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en_i && addr_i == A_CENT) && !(freeze_q && !freeze_i))
            |=> $stable(cur_q[A_CENT][7]));  // R7

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .done_o    (done_o),
    .freeze_i  (freeze_i),
    .freeze_q  (freeze_q),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .rd_data_o (rd_data_o),
    .usr_q     (usr_q),
    .cur_q     (cur_q)
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
    import rtc_cal_pkg::*;

    logic              clk   = 1'b0;
    logic              rst   = 1'b1;
    logic              tick  = 1'b0;
    logic              fbin  = 1'b0;
    logic              f24   = 1'b1;
    logic              dse   = 1'b0;
    logic              frz   = 1'b0;
    logic              wr    = 1'b0;
    logic [ADDR_W-1:0] addr  = '0;
    logic [BYTE_W-1:0] wdata = '0;
    logic [BYTE_W-1:0] rdata;
    logic              done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // reference model state, binary, hours 0..23
    int ms, mm, mh, mdw, mdt, mmo, myr, mcent;
    bit mfb;

    always #5 clk = ~clk;

    rtc_calendar_core u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .fmt_bin_i (fbin),
        .fmt_24h_i (f24),
        .dst_en_i  (dse),
        .freeze_i  (frz),
        .wr_en_i   (wr),
        .addr_i    (addr),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .done_o    (done)
    );

    function automatic int enc(int v);
        return fbin ? v : ((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int exp_byte(int a);
        int h12;
        case (a)
            0: return enc(ms);
            1: return enc(mm);
            2: begin
                if (f24) return enc(mh);
                h12 = (mh % 12 == 0) ? 12 : mh % 12;
                return ((mh >= 12) ? 128 : 0) | enc(h12);
            end
            3: return enc(mdw);
            4: return enc(mdt);
            5: return enc(mmo);
            6: return enc(myr);
            default: return mcent;
        endcase
    endfunction

    task automatic model_tick();
        if (dse && mh == 1 && mm == 59 && ms == 59 && mdw == 1 && mmo == 4 && mdt <= 7) begin
            mh = 3; mm = 0; ms = 0;
        end else if (dse && mh == 1 && mm == 59 && ms == 59 && mdw == 1 && mmo == 10
                     && mdt >= 25 && !mfb) begin
            mm = 0; ms = 0; mfb = 1;
        end else begin
            ms++;
            if (ms == 60) begin
                ms = 0; mm++;
                if (mm == 60) begin
                    mm = 0; mh++;
                    if (mh == 24) begin
                        mh = 0; mfb = 0;
                        mdw = (mdw % 7) + 1;
                        mdt++;
                        if (mdt > mdays(mmo, myr)) begin
                            mdt = 1; mmo++;
                            if (mmo == 13) begin
                                mmo = 1; myr++;
                                if (myr == 100) begin
                                    myr = 0;
                                    mcent = (mcent & 128) | 32;
                                end
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(int a, int d);
        @(negedge clk);
        addr  = a[ADDR_W-1:0];
        wdata = d[BYTE_W-1:0];
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        addr = a[ADDR_W-1:0];
        #1 v = int'(rdata);
    endtask

    task automatic check_all(string req);
        for (int a = 0; a < NUM_REGS; a++) begin
            int v;
            rd(a, v);
            chk(v, exp_byte(a), req);
        end
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
    endtask

    task automatic load(int s, int m, int h, int dw, int dt, int mo, int yr);
        ms = s; mm = m; mh = h; mdw = dw; mdt = dt; mmo = mo; myr = yr;
        for (int a = 0; a < 7; a++) wr_byte(a, exp_byte(a));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int v;
        v = int'($urandom(32'd424242));
        ms = 0; mm = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; myr = 0; mcent = 32; mfb = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 R2: reset contents through the address map
        @(negedge clk);
        chk(int'(done), 0, "R1 done low");
        check_all("R1 R2 reset bytes");

        // R3 R5 R13: BCD month end with strobe timing
        load(59, 59, 23, 3, 30, 6, 23);
        check_all("R14 direct write");
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
        chk(int'(done), 1, "R13 strobe high");
        @(negedge clk);
        chk(int'(done), 0, "R13 strobe one cycle");
        check_all("R3 R5 June end BCD");

        // R5: weekday 7 wraps to 1
        load(59, 59, 23, 7, 10, 3, 23);
        do_tick();
        check_all("R5 weekday wrap");

        // R6: leap and common February, binary short month
        load(59, 59, 23, 2, 28, 2, 24);
        do_tick();
        check_all("R6 leap Feb 28");
        load(59, 59, 23, 3, 29, 2, 24);
        do_tick();
        check_all("R6 leap Feb 29");
        load(59, 59, 23, 3, 28, 2, 23);
        do_tick();
        check_all("R6 common Feb");
        fbin = 1'b1;
        load(59, 59, 23, 4, 30, 4, 23);
        do_tick();
        check_all("R6 R3 binary April");
        fbin = 1'b0;

        // R7: year wrap loads century, keeps bit 7
        mcent = 8'h95;
        wr_byte(7, mcent);
        load(59, 59, 23, 5, 31, 12, 99);
        do_tick();
        check_all("R7 century wrap");

        // R4: 12-hour boundaries in both formats
        f24 = 1'b0;
        for (int b = 0; b < 2; b++) begin
            fbin = b[0];
            load(59, 59, 11, 2, 5, 5, 21);
            do_tick();
            check_all("R4 AM to noon");
            load(59, 59, 12, 2, 5, 5, 21);
            do_tick();
            check_all("R4 12 to 1 PM");
            load(59, 59, 23, 2, 5, 5, 21);
            do_tick();
            check_all("R4 PM to midnight");
        end
        f24 = 1'b1;
        fbin = 1'b0;

        // R8: spring jump, and no jump outside first week
        dse = 1'b1;
        load(59, 59, 1, 1, 3, 4, 22);
        do_tick();
        check_all("R8 spring jump");
        load(59, 59, 1, 1, 10, 4, 22);
        do_tick();
        check_all("R8 no jump week two");

        // R9: autumn fall-back once
        load(59, 59, 1, 1, 30, 10, 22);
        do_tick();
        check_all("R9 first pass falls back");
        for (int i = 0; i < 3599; i++) do_tick();
        check_all("R9 repeated hour end");
        do_tick();
        check_all("R9 second pass continues");
        dse = 1'b0;

        // R12: seconds MSB ignored
        load(0, 10, 8, 2, 2, 2, 22);
        wr_byte(0, 8'hD9);
        ms = 59;
        rd(0, v);
        chk(v, 8'h59, "R12 seconds MSB");

        // R10 R11: freeze, tick, write, release
        load(30, 20, 10, 5, 14, 5, 24);
        @(negedge clk);
        frz = 1'b1;
        for (int i = 0; i < 5; i++) do_tick();
        rd(0, v);
        chk(v, 8'h30, "R10 frozen seconds");
        rd(1, v);
        chk(v, 8'h20, "R10 frozen minutes");
        wr_byte(1, 8'h45);
        rd(1, v);
        chk(v, 8'h45, "R10 write into view");
        @(negedge clk);
        frz = 1'b0;
        mm = 45;
        check_all("R11 release merge");

        // R3: constrained random times with carries
        for (int it = 0; it < 40; it++) begin
            int s, m, h, dw, dt, mo, yr, k;
            fbin = 1'($urandom % 2);
            f24  = 1'($urandom % 2);
            yr = int'($urandom % 100);
            mo = 1 + int'($urandom % 12);
            dt = 1 + int'($urandom % 32'(mdays(mo, yr)));
            dt = ($urandom % 3 == 0) ? mdays(mo, yr) : dt;
            h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            m  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            s  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            dw = 1 + int'($urandom % 7);
            k  = 1 + int'($urandom % 3);
            load(s, m, h, dw, dt, mo, yr);
            for (int j = 0; j < k; j++) do_tick();
            check_all("R3 random");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule